// File: doc/BRIEF.md
# Parallel Converter Latch Front End

This block is the digital side of a parallel-loaded digital-to-analog converter. A host reaches it over a data bus with a chip select and a read/write select. The bus can load a host latch and read its contents back for diagnostics and calibration. A separate transfer strobe copies the host latch into the code latch, and the code latch feeds the conversion core. A clear input forces the code latch to a known value, and the read/write select at that moment picks the value: all zeros gives 0 V in a unipolar setup, and only the top bit set gives 0 V in a bipolar setup.

Every control is active low and is sampled on the rising edge of `clk`. The bidirectional bus is modelled as a separate input word, a registered output word and an output enable, which the chip level combines into a three-state pad. A readback appears on the output pins one cycle after the edge that samples it. The code latch is exposed as `conv_code`.

Top module: `dac_latch_front`

## Requirements
- R1: While `rst` is high at a clock edge, the host latch and the code latch are cleared to all zeros, and `bus_oe` and `bus_out` are cleared to 0.
- R2: At an edge where `sel_n`=0 and `rd_wr_n`=0, the host latch takes the value on `bus_in`.
- R3: At an edge where `sel_n`=0 and `rd_wr_n`=1, `bus_oe` becomes 1 and `bus_out` becomes the host latch value held before that edge.
- R4: At an edge where `sel_n`=1, `bus_oe` and `bus_out` become 0 and the host latch holds its value. At a write edge, `bus_oe` and `bus_out` also become 0.
- R5: At an edge where `xfer_n`=0 and `clr_n`=1, the code latch takes the host latch value held before that edge, whatever `sel_n` is. A write in the same edge therefore reaches the code latch only at a later transfer.
- R6: At an edge where `clr_n`=0 and `rd_wr_n`=0, the code latch becomes all zeros.
- R7: At an edge where `clr_n`=0 and `rd_wr_n`=1, the code latch becomes the midscale code: only the most significant bit (bit W-1) is set, which is 0x8000 for W=16.
- R8: When `clr_n`=0 and `xfer_n`=0 at the same edge, the clear wins and the host latch value is not copied.
- R9: A clear changes only the code latch. The host latch value, as read back, is unchanged by it.
- R10: At an edge where `clr_n`=1 and `xfer_n`=1, the code latch holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| sel_n | input | 1 | Active-low chip select for the bus |
| rd_wr_n | input | 1 | 1 = read back / midscale clear; 0 = write / zero clear |
| xfer_n | input | 1 | Active-low transfer strobe from the host latch to the code latch |
| clr_n | input | 1 | Active-low clear of the code latch |
| bus_in | input | W | Data bus as seen by the block |
| bus_out | output | W | Readback word; zero when not driving |
| bus_oe | output | 1 | Bus driver enable for the pad |
| conv_code | output | W | Code latch contents to the conversion core |

## Verification
Clear and transfer can fall in the same cycle. So can a host write and a transfer, and the clear shares the read/write select with the bus access in that cycle. The bench provokes these collisions by sweeping all sixteen combinations of the four controls over several data words. A bench model built from the requirements predicts the result for each combination: clear before transfer, a transfer that takes the pre-edge host value, and a clear value picked by the same select that drives the bus. The bench compares the code latch, the enable and the readback word with the model after every edge.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_ZERO = 2'd2,
        OP_MID  = 2'd3
    } conv_op_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        conv_op_t op;
    } ctl_t;

    // Clear outranks transfer; the read/write select picks the clear value.
    function automatic conv_op_t pick_op(input logic clr_n, input logic xfer_n,
                                         input logic rd_wr_n);
        if (!clr_n)
            return rd_wr_n ? OP_MID : OP_ZERO;
        else if (!xfer_n)
            return OP_LOAD;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/dlf_decode.sv
module dlf_decode
    import dlf_pkg::*;
(
    input  logic sel_n,
    input  logic rd_wr_n,
    input  logic xfer_n,
    input  logic clr_n,
    output ctl_t ctl
);
    always_comb begin
        ctl.wr = !sel_n && !rd_wr_n;
        ctl.rd = !sel_n &&  rd_wr_n;
        ctl.op = pick_op(clr_n, xfer_n, rd_wr_n);
    end
endmodule

// File: rtl/dlf_host_latch.sv
module dlf_host_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] dout,
    output logic         oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            dout <= '0;
            oe   <= 1'b0;
        end else begin
            if (wr)
                q <= d;
            oe   <= rd;
            dout <= rd ? q : '0;
        end
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> q == $past(d));
    assert_hold_unless_write_R4: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));
    assert_readback_value_R3: assert property (@(posedge clk) disable iff (rst)
        rd |=> oe && dout == $past(q));
endmodule

// File: rtl/dlf_conv_latch.sv
module dlf_conv_latch
    import dlf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  conv_op_t     op,
    input  logic [W-1:0] src,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] ZERO_CODE = '0;
    localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] next_code;

    always_comb begin
        unique case (op)
            OP_LOAD: next_code = src;
            OP_ZERO: next_code = ZERO_CODE;
            OP_MID:  next_code = MID_CODE;
            default: next_code = code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else
            code <= next_code;
    end

    assert_transfer_copy_R5: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> code == $past(src));
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        op == OP_ZERO |=> code == '0);
    assert_clear_mid_R7: assert property (@(posedge clk) disable iff (rst)
        op == OP_MID |=> $countones(code) == 1 && code[W-1]);
    assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(code));
endmodule

// File: rtl/dac_latch_front.sv
module dac_latch_front
    import dlf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         rd_wr_n,
    input  logic         xfer_n,
    input  logic         clr_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic [W-1:0] conv_code
);
    ctl_t         ctl;
    logic [W-1:0] host_q;

    dlf_decode u_decode (
        .sel_n   (sel_n),
        .rd_wr_n (rd_wr_n),
        .xfer_n  (xfer_n),
        .clr_n   (clr_n),
        .ctl     (ctl)
    );

    dlf_host_latch #(.W(W)) u_host (
        .clk  (clk),
        .rst  (rst),
        .wr   (ctl.wr),
        .rd   (ctl.rd),
        .d    (bus_in),
        .q    (host_q),
        .dout (bus_out),
        .oe   (bus_oe)
    );

    dlf_conv_latch #(.W(W)) u_conv (
        .clk  (clk),
        .rst  (rst),
        .op   (ctl.op),
        .src  (host_q),
        .code (conv_code)
    );

    assert_idle_bus_R4: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !bus_oe && bus_out == '0);
    assert_clear_beats_xfer_R8: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !xfer_n && !rd_wr_n) |=> conv_code == '0);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> !bus_oe && bus_out == '0 && conv_code == '0);
endmodule

// File: tb/dac_latch_front_bench.sv
module dac_latch_front_bench;
    localparam int W = 16;
    localparam logic [W-1:0] MID = 16'h8000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1, rd_wr_n = 1'b0, xfer_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out, conv_code;
    logic         bus_oe;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] m_host = '0, m_conv = '0, m_out = '0;
    logic         m_oe = 1'b0;

    always #4 clk = ~clk;

    dac_latch_front #(.W(W)) u_dac_latch_front (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_wr_n(rd_wr_n),
        .xfer_n(xfer_n), .clr_n(clr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .conv_code(conv_code)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, let one edge pass, update model, compare at next negedge.
    task automatic step(input logic s, input logic rw, input logic x,
                        input logic c, input logic [W-1:0] d);
        logic [W-1:0] nh, nc;
        sel_n = s; rd_wr_n = rw; xfer_n = x; clr_n = c; bus_in = d;
        @(posedge clk);
        nh = (!s && !rw) ? d : m_host;
        if (!c)      nc = rw ? MID : '0;
        else if (!x) nc = m_host;
        else         nc = m_conv;
        m_oe  = !s && rw;
        m_out = m_oe ? m_host : '0;
        m_host = nh; m_conv = nc;
        @(negedge clk);
        if (!c && !x)     chk("R8 code", conv_code, m_conv);
        else if (!c && rw) chk("R7 code", conv_code, m_conv);
        else if (!c)      chk("R6 code", conv_code, m_conv);
        else if (!x)      chk("R5 code", conv_code, m_conv);
        else              chk("R10 code", conv_code, m_conv);
        if (s) begin
            chk("R4 oe", {{(W-1){1'b0}}, bus_oe}, {{(W-1){1'b0}}, m_oe});
            chk("R4 out", bus_out, m_out);
        end else begin
            chk("R3 oe", {{(W-1){1'b0}}, bus_oe}, {{(W-1){1'b0}}, m_oe});
            chk("R3 out", bus_out, m_out);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] pat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 code", conv_code, '0);
        chk("R1 oe", {{(W-1){1'b0}}, bus_oe}, '0);
        chk("R1 out", bus_out, '0);
        rst = 1'b0;
        // R1: host latch reads back zero
        step(1'b0, 1'b1, 1'b1, 1'b1, '0);
        chk("R1 host", bus_out, '0);
        // R2: write then read back
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'h1234);
        step(1'b0, 1'b1, 1'b1, 1'b1, '0);
        chk("R2 readback", bus_out, 16'h1234);
        // Sweep all control combinations over several data words
        for (int p = 0; p < 8; p++) begin
            pat = W'((p * 16'h3a97) ^ (p << 13) ^ 16'h0f0f);
            for (int c = 0; c < 16; c++) begin
                logic [3:0] k;
                k = 4'(c);
                step(k[3], k[2], k[1], k[0], pat ^ W'(c * 16'h0101));
            end
        end
        // R9: clear leaves host latch intact (both clear flavours)
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'hBEEF);
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);
        step(1'b0, 1'b1, 1'b1, 1'b1, 16'h0000);
        chk("R9 host after clear", bus_out, 16'hBEEF);
        // R5: write and transfer in the same edge copy the old value
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'h7777);
        chk("R5 same-edge", conv_code, 16'hBEEF);
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
        chk("R5 later xfer", conv_code, 16'h7777);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule